// File: doc/BRIEF.md
# Programmable Post-Scale Clock Divider

The block divides a fast oscillator clock by an integer value C and produces one output clock. It receives eight copies of the oscillator clock, spaced an eighth of a period apart. It counts on one of them and produces an output period of exactly C oscillator cycles.

The high time of the output is set in half oscillator cycles, so the duty-cycle step is 50%/C. The position of the output is set in two ways: a fine tap choice in eighth-period steps, and a coarse delay in whole cycles. These two settings are independent of the duty setting, so two instances can be set up to give non-overlapping clocks. A feedback flag forces an exact 50% duty on an output that drives a loop feedback path.

While the output runs, new settings are queued by a load strobe. They take effect only at a period boundary, so the output never carries a shortened pulse.

Top module: `vco_post_div`

## Requirements
- R1: The output repeats every C cycles of the selected tap, where C is `div_i` (integer only). When C is 2 or more, the output has exactly one high pulse in each period.
- R2: The output is high for H half-cycles of the selected tap at the start of each period, where H is `high_i`. For example, with C = 10, H = 1..18 gives 5%..90% duty in 5% steps.
- R3: An H of 0 is treated as 1, and an H above 2C−1 is treated as 2C−1.
- R4: Tap k of `vco_ph_i` lags tap 0 by k/8 of a period. Every output edge coincides with an edge of tap `ph_sel_i`. The select value is taken only while `rst_ni` is low.
- R5: When `fb_mode_i` is 1, H is forced to C (50% duty), whatever value `high_i` holds.
- R6: Let E0 be the first rising edge of the selected tap after reset release. The first output rise then falls on the rising edge D+1 edges after E0, where D is `coarse_i`. Before that rise the output is low.
- R7: A C of 0 or 1 selects bypass. The output then equals the selected tap from the second tap rise after release, and H and D have no effect.
- R8: `load_i`, sampled on a tap rise, captures C, H (with the clamping of R3 and R5) and D. They take effect at the first period boundary after that edge. If the new D is non-zero and the new C is 2 or more, the output stays low for D cycles, starting with the cycle at that boundary, and then starts a full period. A load on E0 is ignored.
- R9: The output is low while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_ph_i | input | NTAP (8) | Oscillator phase taps, tap k lagging by k/NTAP period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ph_sel_i | input | SEL_W (3) | Fine phase: index of the tap to count on |
| div_i | input | DIV_W (8) | Post-scale divide value C |
| high_i | input | DIV_W+1 (9) | High time H in half-cycles |
| coarse_i | input | CRS_W (8) | Coarse delay D in whole cycles |
| fb_mode_i | input | 1 | Feedback output: forces 50% duty |
| load_i | input | 1 | Strobe that queues new C, H and D |
| clk_o | output | 1 | Divided output clock |

## Verification
Every result is tied to edges of the selected tap. The output level for each half-cycle is settled right after the tap edge that opens that half. The bench therefore samples 2 ns (a quarter period) after every rising and every falling tap edge and compares against a cycle-by-cycle model. In that model E0 is a low cycle, the first rise is due D+1 rising edges later, and a load sampled on one rising edge first changes the output at the boundary edge that follows it. The reset level is sampled while reset is held. The fine phase is checked from the arrival time of an output rise modulo the tap period.

// File: rtl/pscale_pkg.sv
package pscale_pkg;
  typedef enum logic [1:0] {
    ST_INIT,  // first edge after reset: take the configuration
    ST_WAIT,  // coarse delay, output held low
    ST_RUN    // counting periods
  } ps_state_e;
endpackage

// File: rtl/pscale_tap_sel.sv
module pscale_tap_sel #(
  parameter int NTAP  = 8,
  parameter int SEL_W = $clog2(NTAP)
) (
  input  logic [NTAP-1:0]  ph_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o
);
  logic [SEL_W-1:0] sel_q;

  // selection follows the input only while reset is held: no switching while running
  always_ff @(posedge ph_i[0]) begin
    if (!rst_ni) sel_q <= sel_i;
  end

  assign clk_o = ph_i[sel_q];
endmodule

// File: rtl/pscale_ctrl.sv
module pscale_ctrl
  import pscale_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CRS_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [DIV_W:0]     high_i,
  input  logic [CRS_W-1:0]   coarse_i,
  input  logic               fb_i,
  input  logic               load_i,
  output logic               p_o,
  output logic               nx_odd_o,
  output logic               nx_byp_o
);
  localparam int HI_W  = DIV_W + 1;
  localparam int DLY_W = CRS_W + 1;

  ps_state_e        st_q, st_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [DIV_W-1:0] act_div_q, act_div_d, sh_div_q;
  logic [HI_W-1:0]  act_hi_q, act_hi_d, sh_hi_q;
  logic [CRS_W-1:0] sh_crs_q;
  logic             pend_q, p_q;

  logic [DIV_W-1:0] div_c;
  logic [HI_W-1:0]  lim_c, hi_c;
  logic             bnd, take;
  logic             run_d, p_d, odd_d, byp_d;

  // legalise incoming settings
  always_comb begin
    div_c = (div_i == '0) ? DIV_W'(1) : div_i;
    lim_c = {div_c, 1'b0} - HI_W'(1);
    if (div_c == DIV_W'(1))   hi_c = HI_W'(1);
    else if (fb_i)            hi_c = HI_W'(div_c);
    else if (high_i == '0)    hi_c = HI_W'(1);
    else if (high_i > lim_c)  hi_c = lim_c;
    else                      hi_c = high_i;
  end

  assign bnd  = (st_q == ST_RUN) && (cnt_q == act_div_q - DIV_W'(1));
  assign take = load_i && (st_q != ST_INIT);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    dly_d     = dly_q;
    act_div_d = act_div_q;
    act_hi_d  = act_hi_q;
    unique case (st_q)
      ST_INIT: begin
        act_div_d = div_c;
        act_hi_d  = hi_c;
        cnt_d     = '0;
        if (div_c == DIV_W'(1)) st_d = ST_RUN;
        else begin
          st_d  = ST_WAIT;
          dly_d = DLY_W'(coarse_i) + DLY_W'(1);
        end
      end
      ST_WAIT: begin
        if (dly_q <= DLY_W'(1)) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end else begin
          dly_d = dly_q - DLY_W'(1);
        end
      end
      default: begin
        if (bnd) begin
          cnt_d = '0;
          if (pend_q) begin
            act_div_d = sh_div_q;
            act_hi_d  = sh_hi_q;
            if (sh_div_q != DIV_W'(1) && sh_crs_q != '0) begin
              st_d  = ST_WAIT;
              dly_d = DLY_W'(sh_crs_q);
            end
          end
        end else begin
          cnt_d = cnt_q + DIV_W'(1);
        end
      end
    endcase
  end

  // what the next tap cycle looks like; the falling-edge stage needs it early
  always_comb begin
    run_d = (st_q != ST_INIT) && (st_d == ST_RUN);
    byp_d = run_d && (act_div_d == DIV_W'(1));
    p_d   = run_d && !byp_d &&
            ((HI_W+1)'({cnt_d, 1'b0}) + (HI_W+1)'(2) <= (HI_W+1)'(act_hi_d));
    odd_d = run_d && !byp_d && act_hi_d[0] &&
            (HI_W'(cnt_d) == (act_hi_d >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_INIT;
      cnt_q     <= '0;
      dly_q     <= '0;
      act_div_q <= DIV_W'(1);
      act_hi_q  <= HI_W'(1);
      sh_div_q  <= DIV_W'(1);
      sh_hi_q   <= HI_W'(1);
      sh_crs_q  <= '0;
      pend_q    <= 1'b0;
      p_q       <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      dly_q     <= dly_d;
      act_div_q <= act_div_d;
      act_hi_q  <= act_hi_d;
      p_q       <= p_d;
      if (take) begin
        sh_div_q <= div_c;
        sh_hi_q  <= hi_c;
        sh_crs_q <= coarse_i;
        pend_q   <= 1'b1;
      end else if (bnd) begin
        pend_q   <= 1'b0;
      end
    end
  end

  assign p_o      = p_q;
  assign nx_odd_o = odd_d;
  assign nx_byp_o = byp_d;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> (cnt_q < act_div_q)); // R1
  AST_HIGH_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_INIT && act_div_q > DIV_W'(1)) |->
      (act_hi_q >= HI_W'(1) && act_hi_q <= {act_div_q, 1'b0} - HI_W'(1))); // R3
  AST_WAIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> !p_q); // R6
  AST_RELOAD_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_div_q != $past(act_div_q) || act_hi_q != $past(act_hi_q)) |->
      $past(st_q == ST_INIT || (st_q == ST_RUN && cnt_q == act_div_q - DIV_W'(1)))); // R8
endmodule

// File: rtl/pscale_edge.sv
module pscale_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic p_i,
  input  logic nx_odd_i,
  input  logic nx_byp_i,
  output logic clk_o
);
  logic odd_n_q, byp_n_q;

  // enables retimed on the falling edge so the clock gate opens only while the tap is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_n_q <= 1'b0;
      byp_n_q <= 1'b0;
    end else begin
      odd_n_q <= nx_odd_i;
      byp_n_q <= nx_byp_i;
    end
  end

  assign clk_o = p_i | (clk_i & (odd_n_q | byp_n_q));

  AST_BYP_NO_P: assert property (@(negedge clk_i) disable iff (!rst_ni)
    byp_n_q |-> !p_i); // R7
endmodule

// File: rtl/vco_post_div.sv
module vco_post_div #(
  parameter int NTAP  = 8,
  parameter int DIV_W = 8,
  parameter int CRS_W = 8,
  localparam int SEL_W = $clog2(NTAP)
) (
  input  logic [NTAP-1:0]  vco_ph_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] ph_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W:0]   high_i,
  input  logic [CRS_W-1:0] coarse_i,
  input  logic             fb_mode_i,
  input  logic             load_i,
  output logic             clk_o
);
  logic tap_clk, p, nx_odd, nx_byp;

  pscale_tap_sel #(.NTAP(NTAP), .SEL_W(SEL_W)) u_tap (
    .ph_i   (vco_ph_i),
    .rst_ni (rst_ni),
    .sel_i  (ph_sel_i),
    .clk_o  (tap_clk)
  );

  pscale_ctrl #(.DIV_W(DIV_W), .CRS_W(CRS_W)) u_ctrl (
    .clk_i    (tap_clk),
    .rst_ni   (rst_ni),
    .div_i    (div_i),
    .high_i   (high_i),
    .coarse_i (coarse_i),
    .fb_i     (fb_mode_i),
    .load_i   (load_i),
    .p_o      (p),
    .nx_odd_o (nx_odd),
    .nx_byp_o (nx_byp)
  );

  pscale_edge u_edge (
    .clk_i    (tap_clk),
    .rst_ni   (rst_ni),
    .p_i      (p),
    .nx_odd_i (nx_odd),
    .nx_byp_i (nx_byp),
    .clk_o    (clk_o)
  );
endmodule

// File: tb/vco_post_div_bench.sv
`timescale 1ns/1ps
module vco_post_div_bench;
  logic [2:0] ph_t = 3'd0;
  logic [7:0] vco;
  logic       rst_n = 1'b1;
  logic       fb = 1'b0, ld = 1'b0;
  logic [2:0] cur_sel = 3'd0;
  logic [7:0] div = 8'd2, crs = 8'd0;
  logic [8:0] hi = 9'd1;
  logic       clk_out, tap_sel;

  always #1 ph_t = ph_t + 3'd1;  // taps: 125 MHz, 1 ns apart
  for (genvar k = 0; k < 8; k++) begin : g_tap
    assign vco[k] = (3'(ph_t - 3'(k)) < 3'd4);
  end
  assign tap_sel = vco[cur_sel];

  vco_post_div u_vco_post_div (
    .vco_ph_i(vco), .rst_ni(rst_n), .ph_sel_i(cur_sel), .div_i(div),
    .high_i(hi), .coarse_i(crs), .fb_mode_i(fb), .load_i(ld), .clk_o(clk_out)
  );

  int  n_chk = 0, n_fail = 0, mism, mm_act, mm_exp;
  real last_rise;
  int  m_c, m_h, m_d, s_c, s_h, s_d, m_idx, m_low;
  bit  m_init, m_pend, e1, e2;

  always @(posedge clk_out) last_rise = $realtime;

  function automatic int cl_c(int c);
    return (c == 0) ? 1 : c;
  endfunction
  function automatic int cl_h(int c, int h, bit f);
    if (c == 1) return 1;
    if (f) return c;
    if (h == 0) return 1;
    if (h > 2*c - 1) return 2*c - 1;
    return h;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one tap rise of the reference model
  task automatic model_step();
    bit was_init = m_init;
    if (m_init) begin
      m_c = cl_c(int'(div)); m_h = cl_h(m_c, int'(hi), fb); m_d = int'(crs);
      m_init = 0; m_pend = 0; m_idx = -1;
      m_low = (m_c == 1) ? 0 : m_d;
    end else if (m_low > 0) begin
      m_low--;
    end else if (m_idx == -1) begin
      m_idx = 0;
    end else if (m_idx == m_c - 1) begin
      if (m_pend) begin
        m_c = s_c; m_h = s_h; m_d = s_d; m_pend = 0;
        if (m_c != 1 && m_d > 0) begin m_low = m_d - 1; m_idx = -1; end
        else m_idx = 0;
      end else m_idx = 0;
    end else begin
      m_idx++;
    end
    if (ld && !was_init) begin
      s_c = cl_c(int'(div)); s_h = cl_h(s_c, int'(hi), fb); s_d = int'(crs); m_pend = 1;
    end
    if (m_idx < 0)       begin e1 = 0; e2 = 0; end
    else if (m_c == 1)   begin e1 = 1; e2 = 0; end
    else begin e1 = (2*m_idx < m_h); e2 = (2*m_idx + 1 < m_h); end
  endtask

  task automatic cmp(bit e);
    if (clk_out !== e) begin
      if (mism == 0) begin mm_act = int'(clk_out); mm_exp = int'(e); end
      mism++;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge tap_sel); model_step(); #2; cmp(e1);
      @(negedge tap_sel); #2; cmp(e2);
    end
  endtask

  task automatic start(int c, int h, int d, int sel, bit f);
    rst_n = 1'b0; ld = 1'b0;
    div = 8'(c); hi = 9'(h); crs = 8'(d); cur_sel = 3'(sel); fb = f;
    repeat (3) @(posedge vco[0]);
    #3 check(clk_out == 1'b0, "R9", "output during reset", int'(clk_out), 0);
    @(negedge tap_sel); #2;
    rst_n = 1'b1; m_init = 1; mism = 0; last_rise = -1.0;
  endtask

  task automatic finish(string req, string name);
    check(mism == 0, req, {name, " waveform"}, mm_act, mm_exp);
    if (last_rise >= 0.0)
      check(($rtoi(last_rise) % 8) == int'(cur_sel), "R4", {name, " phase"},
            $rtoi(last_rise) % 8, int'(cur_sel));
  endtask

  task automatic scen(string req, string name, int c, int h, int d, int sel, bit f);
    start(c, h, d, sel, f);
    run(d + 3 + 3*cl_c(c));
    finish(req, name);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(1234);
    #1 rst_n = 1'b0;
    scen("R2", "c10 h1 5pct",  10, 1,  0, 0, 0);
    scen("R2", "c10 h18 90pct",10, 18, 0, 5, 0);
    scen("R1", "c7 h7",         7, 7,  0, 2, 0);
    scen("R6", "c5 h7 d3",      5, 7,  3, 3, 0);
    scen("R6", "c3 h2 d7",      3, 2,  7, 1, 0);
    scen("R3", "h0 clamp",      4, 0,  1, 2, 0);
    scen("R3", "h200 clamp",    4, 200,0, 1, 0);
    scen("R5", "fb c5",         5, 2,  0, 7, 1);
    scen("R5", "fb c6",         6, 11, 2, 4, 1);
    scen("R7", "bypass c1",     1, 9,  5, 6, 0);
    scen("R7", "bypass c0",     0, 3,  2, 4, 0);
    // reload with coarse delay, then input noise without a load
    start(4, 4, 0, 1, 0);
    run(6);
    div = 8'd6; hi = 9'd3; crs = 8'd2; ld = 1'b1;
    run(1);
    ld = 1'b0; div = 8'd9; hi = 9'd1; crs = 8'd0;
    run(24);
    finish("R8", "reload c6 h3 d2");
    // reload into bypass and back out
    start(5, 3, 0, 0, 0);
    run(3);
    div = 8'd1; ld = 1'b1; run(1); ld = 1'b0;
    run(8);
    div = 8'd3; hi = 9'd5; crs = 8'd1; ld = 1'b1; run(1); ld = 1'b0;
    run(12);
    finish("R8", "reload bypass");
    // constrained random
    for (int t = 0; t < 10; t++) begin
      int c = 1 + int'($urandom % 12);
      int h = int'($urandom % 26);
      int d = int'($urandom % 5);
      int s = int'($urandom % 8);
      bit f = ($urandom % 4) == 0;
      start(c, h, d, s, f);
      run(d + 2 + int'($urandom % 20));
      if ($urandom % 2 == 1) begin
        div = 8'(1 + $urandom % 12); hi = 9'($urandom % 26); crs = 8'($urandom % 4);
        fb = ($urandom % 4) == 0; ld = 1'b1; run(1); ld = 1'b0;
      end
      run(40);
      finish("R2", $sformatf("random %0d", t));
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule